// File: doc/BRIEF.md
# Reduced-Pin Ethernet Dibit Adapter

This block sits between a MAC that speaks in 4-bit nibbles and a reduced-pin 100 Mb/s PHY link that moves two bits per cycle. Every register runs from the single 50 MHz reference clock that the link uses for both directions; there is no receive clock. On the transmit side the MAC holds a nibble for two reference cycles and the block sends it as two dibits with the transmit enable raised. On the receive side the block puts incoming dibit pairs back into nibbles and gives a one-cycle nibble strobe together with a carrier indication.

A static configuration input chooses how the single receive control line is read. In combined mode it carries carrier sense and data valid together: a frame begins only at the first preamble dibit, and after the carrier goes away the line alternates on nibble boundaries while buffered data drains. In plain data-valid mode the line is simply the validity of each dibit. The input is changed only while no frame is in progress.

Top module: `rmii_adapter`

## Requirements
- R1: A synchronous active-high reset drives `rmii_tx_en`, `mac_rx_dv` and `mac_crs` low in the cycle after the reset edge and clears both phase counters, so no leftover half nibble is sent or assembled once reset is released.
- R2: The nibble on `mac_txd` is sampled on a clock edge where the transmitter is between nibbles and `mac_tx_en` is high; after that edge `rmii_txd` shows bits 1:0, after the next edge bits 3:2 of the nibble held in that first cycle.
- R3: `rmii_tx_en` is high for both dibits of every sampled nibble, even when `mac_tx_en` falls after the first, and low with `rmii_txd` at 00 in every other cycle.
- R4: The first dibit of a nibble lands in `mac_rxd[1:0]` and the second in `mac_rxd[3:2]`; `mac_rx_dv` is a one-cycle pulse that rises after the edge that samples the second dibit, so a running frame yields one pulse every two cycles.
- R5: With `cfg_rx_dv_mode` = 0 (combined), a frame starts only on a cycle where `rmii_crs_dv` is high and `rmii_rxd` is 01; dibits 00, 10 or 11 seen earlier with the line high are dropped and leave `mac_crs` low.
- R6: In combined mode a nibble whose control line is low on the first dibit and high on the second is still delivered; the frame ends, with no strobe, on the first nibble that has the line low on both dibits.
- R7: `mac_crs` rises after the edge that starts a frame; in combined mode it falls after the first edge within the frame that samples the control line low, in data-valid mode after the edge that ends the frame.
- R8: With `cfg_rx_dv_mode` = 1 (data-valid), a frame starts on any dibit (00 included) with the line high and ends at the first cycle the line is low; a half-built nibble at that point is discarded.
- R9: Transmit and receive are independent: a nibble completing on receive in the same cycle as a dibit being sent alters neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock for both directions |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_dv_mode | input | 1 | 0: control line is combined carrier/valid; 1: plain data-valid |
| mac_txd | input | 4 | Transmit nibble from the MAC, held two cycles |
| mac_tx_en | input | 1 | MAC transmit enable |
| rmii_txd | output | 2 | Transmit dibit to the PHY |
| rmii_tx_en | output | 1 | Transmit enable to the PHY |
| rmii_rxd | input | 2 | Receive dibit from the PHY |
| rmii_crs_dv | input | 1 | Receive control line from the PHY |
| mac_rxd | output | 4 | Assembled receive nibble |
| mac_rx_dv | output | 1 | One-cycle strobe marking a new `mac_rxd` |
| mac_crs | output | 1 | Carrier indication to the MAC |

## Verification
The transmit serializer and the receive assembler can both act in the same cycle: a dibit leaves on `rmii_txd` while a nibble strobe appears on `mac_rx_dv`. The bench lays a full transmit sweep of all sixteen nibble values over a combined-mode receive frame in the same cycles, so nibble completions, the carrier drop and the frame end coincide with dibits of both halves of outgoing nibbles. Each cycle's transmit dibit and carrier level, and the value and cycle of every receive strobe, are compared against arithmetic expectations built only from the requirements.

// File: rtl/rmii_adapter_pkg.sv
package rmii_adapter_pkg;
  localparam int DIBIT_W  = 2;
  localparam int NIBBLE_W = 2 * DIBIT_W;

  typedef logic [DIBIT_W-1:0]  dibit_t;
  typedef logic [NIBBLE_W-1:0] nibble_t;

  // Pick the lower (first sent) or upper (second sent) dibit of a nibble.
  function automatic dibit_t nib_slice(nibble_t n, logic upper);
    return upper ? n[NIBBLE_W-1:DIBIT_W] : n[DIBIT_W-1:0];
  endfunction

  // Rebuild a nibble: the first dibit received lands in the low bits.
  function automatic nibble_t nib_join(dibit_t first, dibit_t second);
    return {second, first};
  endfunction
endpackage

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer
  import rmii_adapter_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  nibble_t nib,
  input  logic    nib_en,
  output dibit_t  txd,
  output logic    tx_en,
  output logic    phase_hi,
  output logic    nib_take
);
  nibble_t hold;
  logic    ph;

  // A new nibble is only taken between nibbles.
  assign nib_take = !ph && nib_en;
  assign phase_hi = ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= 1'b0;
      hold  <= '0;
      txd   <= '0;
      tx_en <= 1'b0;
    end else if (nib_take) begin
      hold  <= nib;
      txd   <= nib_slice(nib, 1'b0);
      tx_en <= 1'b1;
      ph    <= 1'b1;
    end else if (ph) begin
      txd   <= nib_slice(hold, 1'b1);
      tx_en <= 1'b1;
      ph    <= 1'b0;
    end else begin
      txd   <= '0;
      tx_en <= 1'b0;
    end
  end
endmodule

// File: rtl/rmii_rx_assembler.sv
module rmii_rx_assembler
  import rmii_adapter_pkg::*;
#(
  parameter dibit_t START_DIBIT = 2'b01
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    dv_mode,
  input  dibit_t  rxd,
  input  logic    ctrl,
  output nibble_t nib,
  output logic    nib_vld,
  output logic    carrier,
  output logic    active,
  output logic    frame_start,
  output logic    frame_end
);
  logic   act;
  logic   ph;
  logic   lo_ctrl;
  dibit_t lo;

  logic start_ok;
  logic dv_stop;
  logic crs_stop;

  assign start_ok    = dv_mode ? ctrl : (ctrl && (rxd == START_DIBIT));
  assign frame_start = !act && start_ok;
  // Data-valid mode: any low cycle ends the frame, dropping a half nibble.
  assign dv_stop     = act && dv_mode && !ctrl;
  // Combined mode: a nibble low on both dibits closes the frame.
  assign crs_stop    = act && !dv_mode && ph && !lo_ctrl && !ctrl;
  assign frame_end   = dv_stop || crs_stop;
  assign active      = act;

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= 1'b0;
      ph      <= 1'b0;
      lo      <= '0;
      lo_ctrl <= 1'b0;
      carrier <= 1'b0;
      nib     <= '0;
      nib_vld <= 1'b0;
    end else begin
      nib_vld <= 1'b0;
      if (frame_start) begin
        act     <= 1'b1;
        ph      <= 1'b1;
        lo      <= rxd;
        lo_ctrl <= ctrl;
        carrier <= 1'b1;
      end else if (frame_end) begin
        act     <= 1'b0;
        ph      <= 1'b0;
        carrier <= 1'b0;
      end else if (act) begin
        if (!dv_mode && !ctrl) carrier <= 1'b0;
        if (!ph) begin
          lo      <= rxd;
          lo_ctrl <= ctrl;
          ph      <= 1'b1;
        end else begin
          nib     <= nib_join(lo, rxd);
          nib_vld <= 1'b1;
          ph      <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rmii_adapter.sv
module rmii_adapter
  import rmii_adapter_pkg::*;
#(
  parameter logic [DIBIT_W-1:0] RX_START_DIBIT = 2'b01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_rx_dv_mode,
  input  logic [NIBBLE_W-1:0] mac_txd,
  input  logic                mac_tx_en,
  output logic [DIBIT_W-1:0]  rmii_txd,
  output logic                rmii_tx_en,
  input  logic [DIBIT_W-1:0]  rmii_rxd,
  input  logic                rmii_crs_dv,
  output logic [NIBBLE_W-1:0] mac_rxd,
  output logic                mac_rx_dv,
  output logic                mac_crs
);
  // Internal events, named for the bound checker.
  logic tx_phase;
  logic tx_take;
  logic rx_active;
  logic rx_frame_start;
  logic rx_frame_end;

  rmii_tx_serializer u_tx (
    .clk      (clk),
    .rst      (rst),
    .nib      (mac_txd),
    .nib_en   (mac_tx_en),
    .txd      (rmii_txd),
    .tx_en    (rmii_tx_en),
    .phase_hi (tx_phase),
    .nib_take (tx_take)
  );

  rmii_rx_assembler #(.START_DIBIT(RX_START_DIBIT)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .dv_mode     (cfg_rx_dv_mode),
    .rxd         (rmii_rxd),
    .ctrl        (rmii_crs_dv),
    .nib         (mac_rxd),
    .nib_vld     (mac_rx_dv),
    .carrier     (mac_crs),
    .active      (rx_active),
    .frame_start (rx_frame_start),
    .frame_end   (rx_frame_end)
  );
endmodule

// File: rtl/rmii_adapter_chk.sv
module rmii_adapter_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_rx_dv_mode,
  input logic [3:0] mac_txd,
  input logic       mac_tx_en,
  input logic [1:0] rmii_txd,
  input logic       rmii_tx_en,
  input logic [1:0] rmii_rxd,
  input logic       rmii_crs_dv,
  input logic       mac_rx_dv,
  input logic       mac_crs,
  input logic       tx_phase,
  input logic       tx_take,
  input logic       rx_active,
  input logic       rx_frame_start,
  input logic       rx_frame_end
);
  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (!rmii_tx_en && !mac_rx_dv && !mac_crs && !rx_active && !tx_phase));

  // R2
  tx_low_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_phase && mac_tx_en) |=> (rmii_tx_en && rmii_txd == $past(mac_txd[1:0])));

  // R3
  tx_second_dibit_chk: assert property (@(posedge clk) disable iff (rst)
    tx_phase |=> (rmii_tx_en && !tx_phase));

  // R3
  tx_take_phase_chk: assert property (@(posedge clk) disable iff (rst)
    tx_take |=> tx_phase);

  // R4
  rx_strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mac_rx_dv |=> !mac_rx_dv);

  // R5
  rx_start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rx_dv_mode && !rx_active && !(rmii_crs_dv && rmii_rxd == 2'b01)) |=> !rx_active);

  // R6
  rx_end_silent_chk: assert property (@(posedge clk) disable iff (rst)
    rx_frame_end |=> (!mac_rx_dv && !rx_active && !mac_crs));

  // R7
  rx_carrier_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rx_dv_mode && rx_active && !rmii_crs_dv) |=> !mac_crs);

  // R7
  rx_carrier_start_chk: assert property (@(posedge clk) disable iff (rst)
    rx_frame_start |=> (mac_crs && rx_active));

  // R8
  rx_dv_low_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rx_dv_mode && !rmii_crs_dv) |=> (!mac_rx_dv && !rx_active));
endmodule

bind rmii_adapter rmii_adapter_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_rx_dv_mode (cfg_rx_dv_mode),
  .mac_txd        (mac_txd),
  .mac_tx_en      (mac_tx_en),
  .rmii_txd       (rmii_txd),
  .rmii_tx_en     (rmii_tx_en),
  .rmii_rxd       (rmii_rxd),
  .rmii_crs_dv    (rmii_crs_dv),
  .mac_rx_dv      (mac_rx_dv),
  .mac_crs        (mac_crs),
  .tx_phase       (tx_phase),
  .tx_take        (tx_take),
  .rx_active      (rx_active),
  .rx_frame_start (rx_frame_start),
  .rx_frame_end   (rx_frame_end)
);

// File: tb/test_rmii_adapter.sv
`timescale 1ns/1ps
module test_rmii_adapter;
  localparam int MAXC = 160;
  localparam int MAXN = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg = 1'b0;
  logic [3:0] mac_txd = '0;
  logic       mac_tx_en = 1'b0;
  logic [1:0] rmii_txd;
  logic       rmii_tx_en;
  logic [1:0] rmii_rxd = '0;
  logic       rmii_crs_dv = 1'b0;
  logic [3:0] mac_rxd;
  logic       mac_rx_dv;
  logic       mac_crs;

  always #2.5 clk = ~clk;

  rmii_adapter i_rmii_adapter (
    .clk(clk), .rst(rst), .cfg_rx_dv_mode(cfg),
    .mac_txd(mac_txd), .mac_tx_en(mac_tx_en),
    .rmii_txd(rmii_txd), .rmii_tx_en(rmii_tx_en),
    .rmii_rxd(rmii_rxd), .rmii_crs_dv(rmii_crs_dv),
    .mac_rxd(mac_rxd), .mac_rx_dv(mac_rx_dv), .mac_crs(mac_crs)
  );

  int ntest = 0;
  int nfail = 0;
  bit done  = 1'b0;

  // Stimulus and expectations, one entry per cycle.
  logic [1:0] rd_a [MAXC];
  logic       rc_a [MAXC];
  logic [3:0] tn_a [MAXC];
  logic       te_a [MAXC];
  logic       xten_a [MAXC];
  logic [1:0] xtxd_a [MAXC];
  logic       xcrs_a [MAXC];
  int ri, ti;
  logic [3:0] xn [MAXN];
  int         xc [MAXN];
  int         xnum;
  logic [3:0] gn [MAXN];
  int         gc [MAXN];
  int         gnum;

  task automatic chk(string req, string what, int act, int exp);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < MAXC; i++) begin
      rd_a[i] = '0; rc_a[i] = 1'b0; tn_a[i] = '0; te_a[i] = 1'b0;
      xten_a[i] = 1'b0; xtxd_a[i] = '0; xcrs_a[i] = 1'b0;
    end
    ri = 0; ti = 0; xnum = 0; gnum = 0;
  endtask

  task automatic rx_push(int d, bit c, bit crs_exp);
    rd_a[ri] = 2'(d); rc_a[ri] = c; xcrs_a[ri] = crs_exp; ri++;
  endtask

  task automatic expect_nib(int v, int cyc);
    xn[xnum] = 4'(v); xc[xnum] = cyc; xnum++;
  endtask

  // Nibble held two cycles; dibit order low then high (R2).
  task automatic tx_nib(int v, bit short_en);
    tn_a[ti] = 4'(v); te_a[ti] = 1'b1; xten_a[ti] = 1'b1; xtxd_a[ti] = 2'(v % 4); ti++;
    tn_a[ti] = 4'(v); te_a[ti] = !short_en; xten_a[ti] = 1'b1; xtxd_a[ti] = 2'(v / 4); ti++;
  endtask

  // Combined-mode frame: lead dibits, two preamble nibbles, data, toggle nibbles, end nibble.
  task automatic build_comb(int lead_n, int lead_v, int nd, int nt, int base);
    int s;
    for (int k = 0; k < lead_n; k++) rx_push(lead_v, 1'b1, 1'b0);
    s = ri;
    for (int k = 0; k < 4; k++) rx_push(1, 1'b1, 1'b1);
    expect_nib(5, s + 1);
    expect_nib(5, s + 3);
    for (int k = 0; k < nd; k++) begin
      int v = (base + k * 7) % 16;
      expect_nib(v, ri + 1);
      rx_push(v % 4, 1'b1, 1'b1);
      rx_push(v / 4, 1'b1, 1'b1);
    end
    for (int k = 0; k < nt; k++) begin
      int v = (base + 9 + k * 5) % 16;
      expect_nib(v, ri + 1);
      rx_push(v % 4, 1'b0, 1'b0);
      rx_push(v / 4, 1'b1, 1'b0);
    end
    rx_push(3, 1'b0, 1'b0);
    rx_push(2, 1'b0, 1'b0);
  endtask

  // Data-valid-mode frame of nd dibits followed by one low cycle.
  task automatic build_dv(int nd, int seed);
    int st = ri;
    int prev = 0;
    for (int k = 0; k < nd; k++) begin
      int d = (k * 3 + seed) % 4;
      rx_push(d, 1'b1, 1'b1);
      if (k % 2 == 1) expect_nib(prev + 4 * d, st + k);
      prev = d;
    end
    rx_push(1, 1'b0, 1'b0);
  endtask

  task automatic run_stim(string rq);
    int n = ((ri > ti) ? ri : ti) + 3;
    for (int i = 0; i < n; i++) begin
      rmii_rxd = rd_a[i]; rmii_crs_dv = rc_a[i];
      mac_txd = tn_a[i]; mac_tx_en = te_a[i];
      @(posedge clk); #1;
      chk("R3", "tx_en", int'(rmii_tx_en), int'(xten_a[i]));
      chk("R2", "txd", int'(rmii_txd), int'(xtxd_a[i]));
      chk("R7", "crs", int'(mac_crs), int'(xcrs_a[i]));
      if (mac_rx_dv && gnum < MAXN) begin
        gn[gnum] = mac_rxd; gc[gnum] = i; gnum++;
      end
    end
    chk(rq, "nibble count", gnum, xnum);
    for (int j = 0; j < xnum && j < gnum; j++) begin
      chk(rq, "nibble value", int'(gn[j]), int'(xn[j]));
      chk("R4", "nibble cycle", gc[j], xc[j]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk); #1;
    chk("R1", "tx_en in reset", int'(rmii_tx_en), 0);
    chk("R1", "rx_dv in reset", int'(mac_rx_dv), 0);
    chk("R1", "crs in reset", int'(mac_crs), 0);
    rst = 1'b0;

    // R1: reset in the middle of a nibble on both paths
    mac_txd = 4'hF; mac_tx_en = 1'b1; rmii_rxd = 2'b01; rmii_crs_dv = 1'b1;
    @(posedge clk); #1;
    chk("R1", "tx_en before mid reset", int'(rmii_tx_en), 1);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", "tx_en after mid reset", int'(rmii_tx_en), 0);
    chk("R1", "crs after mid reset", int'(mac_crs), 0);
    rst = 1'b0; mac_tx_en = 1'b0; mac_txd = '0; rmii_crs_dv = 1'b0; rmii_rxd = '0;
    @(posedge clk); #1;
    chk("R1", "no stale tx dibit", int'(rmii_tx_en), 0);
    chk("R1", "no stale rx strobe", int'(mac_rx_dv), 0);
    @(posedge clk); #1;

    // R9: full transmit sweep laid over a combined-mode receive frame
    clear_stim();
    for (int v = 0; v < 16; v++) tx_nib(v, 1'b0);
    build_comb(1, 0, 3, 2, 6);
    run_stim("R9");

    // R3: enable dropped after the first dibit still yields both dibits
    for (int v = 0; v < 16; v += 5) begin
      clear_stim();
      tx_nib(v, 1'b1);
      tx_nib(15 - v, 1'b1);
      run_stim("R3");
    end

    // R5 R6: combined-mode sweep of lead dibits, data length and toggle nibbles
    cfg = 1'b0;
    for (int li = 0; li < 4; li++)
      for (int lv = 0; lv < 3; lv++)
        for (int nd = 1; nd <= 3; nd++)
          for (int nt = 0; nt <= 2; nt++) begin
            clear_stim();
            build_comb(li, (lv == 0) ? 0 : lv + 1, nd, nt, li * 5 + nd * 3 + nt);
            run_stim((nt > 0) ? "R6" : "R5");
          end

    // R8: data-valid mode, every length and start pattern
    cfg = 1'b1;
    for (int nd = 1; nd <= 9; nd++)
      for (int s = 0; s < 4; s++) begin
        clear_stim();
        build_dv(nd, s);
        run_stim("R8");
      end

    // R8: back-to-back frames separated by a single low cycle
    clear_stim();
    build_dv(5, 0);
    build_dv(4, 2);
    run_stim("R8");

    // R5: in combined mode a 00-led frame is not started by data-valid semantics
    cfg = 1'b0;
    clear_stim();
    for (int k = 0; k < 6; k++) rx_push(0, 1'b1, 1'b0);
    rx_push(0, 1'b0, 1'b0);
    run_stim("R5");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule